// File: doc/BRIEF.md
# In-Place Single-Memory Soft-Decision Interleaver

This block reorders soft-decision bytes on their way from one decoder stage to the next, using a single memory instead of a pair of ping-pong banks, so it needs half the storage. In each accepted symbol slot it reads the word held at the slot's address and writes the incoming word to that same address. The old word leaves the block one cycle later. Because the memory is overwritten as it is drained, the stored data of each block is already in permuted order. The external address generator therefore has to present a different address sequence in every block. That generator is outside this block. The block trusts it to present every address exactly once per block.

After reset the first block only fills the memory, and nothing leaves the block during it. From the second block on, every accepted word produces exactly one output word, and the first output of each block carries a frame marker. Both data ports use valid/ready. A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. An output word is consumed on an edge where `out_valid` and `out_ready` are both high. There is one output register, and `in_ready` is high whenever that register is empty or being drained in the same cycle, so back-pressure reaches the input in the same cycle. The block length is 2^`ADDR_W` words: `ADDR_W` = 16 gives 65536-word blocks, and the default is kept shorter for elaboration.

Top module: `inplace_interleaver`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` and `out_first` are low and `in_ready` is high.
- R2: The first 2^`ADDR_W` accepted words after reset form the fill block. Each is stored at the address presented with it, and none of them raises `out_valid`.
- R3: In every later block, an accepted word raises `out_valid` on the next cycle. `out_data` then equals the word that was held at the presented address before this slot, and the incoming word replaces it.
- R4: `out_first` is high together with the output word of slot 0 of every block after the fill block, and low with every other output word.
- R5: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While that holds, `out_valid`, `out_data` and `out_first` keep their values.
- R6: A cycle with no accepted word changes neither the slot count nor the memory. If the output register is empty or drained in that cycle, `out_valid` is low on the next cycle.
- R7: A reset asserted in the middle of a block clears any pending output and restarts the fill block at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | DATA_W | Soft-decision byte from the upstream stage |
| in_addr | input | ADDR_W | Memory address for this slot, from the address generator |
| out_valid | output | 1 | Interleaved word present |
| out_ready | input | 1 | Downstream stage takes the word this cycle |
| out_data | output | DATA_W | Interleaved soft-decision byte |
| out_first | output | 1 | Output word belongs to slot 0 of its block |

## Verification
`in_ready` is combinational and settles within the cycle in which `out_ready` is driven. The bench checks it half a nanosecond after driving the inputs on the falling edge. The output word, its valid and its frame marker come from one register, so they are due exactly one rising edge after the edge that accepts the word. The bench samples them 1 ns after that edge and compares them with a model updated at acceptance. During a stall the model keeps its previous expectation, so each stalled cycle checks that the outputs hold. After an idle cycle the model expects `out_valid` low.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // word width of one soft decision
  localparam int unsigned ILV_DATA_W = 8;
  // default log2 block length; 16 gives 64K-word blocks
  localparam int unsigned ILV_ADDR_W = 10;
  // memory lane width (one narrow device per lane)
  localparam int unsigned ILV_LANE_W = 4;

  typedef enum logic {
    PH_FILL = 1'b0,
    PH_RUN  = 1'b1
  } ilv_phase_e;
endpackage

// File: rtl/ilv_slot_ctr.sv
module ilv_slot_ctr
  import ilv_pkg::*;
#(
  parameter int unsigned ADDR_W = ILV_ADDR_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  output logic       slot_zero,
  output ilv_phase_e phase
);
  logic [ADDR_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= PH_FILL;
    end else if (step) begin
      cnt <= cnt + 1'b1;
      if (&cnt) phase <= PH_RUN;
    end
  end

  assign slot_zero = (cnt == '0);
endmodule

// File: rtl/ilv_rbw_ram.sv
module ilv_rbw_ram
  import ilv_pkg::*;
#(
  parameter int unsigned DATA_W = ILV_DATA_W,
  parameter int unsigned ADDR_W = ILV_ADDR_W,
  parameter int unsigned LANE_W = ILV_LANE_W   // DATA_W must be a multiple
) (
  input  logic              clk,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned LANES = DATA_W / LANE_W;

  // each lane reads the old word and writes the new one on the same edge
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (en) begin
        q         <= mem[addr];
        mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/ilv_out_stage.sv
module ilv_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic emit,
  input  logic first_in,
  input  logic out_ready,
  output logic out_valid,
  output logic out_first,
  output logic in_ready
);
  // the read register of the memory holds the data; this stage tracks valid
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
    end else if (in_ready) begin
      out_valid <= take && emit;
      out_first <= take && emit && first_in;
    end
  end
endmodule

// File: rtl/inplace_interleaver.sv
module inplace_interleaver
  import ilv_pkg::*;
#(
  parameter int unsigned DATA_W = ILV_DATA_W,
  parameter int unsigned ADDR_W = ILV_ADDR_W,
  parameter int unsigned LANE_W = ILV_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_first
);
  logic       accept;
  logic       slot_zero;
  ilv_phase_e phase;
  logic       emit;

  assign accept = in_valid && in_ready;
  assign emit   = (phase == PH_RUN);

  ilv_slot_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (accept),
    .slot_zero(slot_zero),
    .phase    (phase)
  );

  ilv_rbw_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
    .clk  (clk),
    .en   (accept),
    .addr (in_addr),
    .wdata(in_data),
    .rdata(out_data)
  );

  ilv_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (accept),
    .emit     (emit),
    .first_in (slot_zero),
    .out_ready(out_ready),
    .out_valid(out_valid),
    .out_first(out_first),
    .in_ready (in_ready)
  );
endmodule

// File: rtl/ilv_checker.sv
module ilv_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_first
);
  logic              acc;
  logic [ADDR_W-1:0] slot;
  logic              filled;

  assign acc = in_valid && in_ready;

  // independent slot/phase tracker seen from the ports
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot   <= '0;
      filled <= 1'b0;
    end else if (acc) begin
      slot <= slot + 1'b1;
      if (&slot) filled <= 1'b1;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_first));

  assert_stall_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_fill_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !filled |=> !out_valid);

  assert_one_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    filled && acc |=> out_valid);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc));

  assert_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    filled && acc && (slot == '0) |=> out_first);

  assert_not_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (slot != '0) |=> !out_first);

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && (!out_valid || out_ready) |=> !out_valid);
endmodule

bind inplace_interleaver ilv_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_first(out_first)
);

// File: tb/sim_inplace_interleaver.sv
`timescale 1ns/1ps
module sim_inplace_interleaver;
  localparam int DW  = 8;
  localparam int AW  = 4;
  localparam int BLK = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [AW-1:0] in_addr = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic          out_first;

  always #2.5 clk = ~clk;

  inplace_interleaver #(.DATA_W(DW), .ADDR_W(AW), .LANE_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_addr(in_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_first(out_first)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model
  logic [DW-1:0] mdl [BLK];
  bit            fill = 1'b1;
  int            slot = 0;
  bit            ev = 1'b0;
  bit            ef = 1'b0;
  logic [DW-1:0] ed = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] perm_addr(input int i, input int mul, input int off);
    return AW'((i * mul + off) % BLK);
  endfunction

  // one clock cycle: drive, check ready, update model, check outputs
  task automatic step(input bit v, input logic [DW-1:0] d, input logic [AW-1:0] a,
                      input bit ordy, output bit acc);
    bit    exp_rdy;
    string tag;
    @(negedge clk);
    in_valid = v; in_data = d; in_addr = a; out_ready = ordy;
    #0.5;
    exp_rdy = !ev || ordy;
    chk(in_ready === exp_rdy, "R5", "in_ready", 32'(in_ready), 32'(exp_rdy));
    acc = v && exp_rdy;
    if (acc) begin
      tag = fill ? "R2" : "R3";
      ev  = !fill;
      ed  = mdl[a];
      ef  = !fill && (slot == 0);
      mdl[a] = d;
      if (slot == BLK - 1) fill = 1'b0;
      slot = (slot + 1) % BLK;
    end else if (exp_rdy) begin
      tag = "R6";
      ev  = 1'b0;
      ef  = 1'b0;
    end else begin
      tag = "R5";
    end
    @(posedge clk);
    #1;
    chk(out_valid === ev, tag, "out_valid", 32'(out_valid), 32'(ev));
    if (ev) begin
      chk(out_data === ed, tag, "out_data", 32'(out_data), 32'(ed));
      chk(out_first === ef, "R4", "out_first", 32'(out_first), 32'(ef));
    end
  endtask

  // send one word, retrying while stalled; random idle gaps and back-pressure
  task automatic send(input logic [DW-1:0] d, input logic [AW-1:0] a, input bit rnd);
    bit acc;
    bit dummy;
    if (rnd && $urandom_range(0, 4) == 0)
      step(1'b0, DW'($urandom), AW'($urandom), bit'($urandom_range(0, 1)), dummy);
    do begin
      step(1'b1, d, a, rnd ? ($urandom_range(0, 3) != 0) : 1'b1, acc);
    end while (!acc);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0, tag, "out_valid in reset", 32'(out_valid), 0);
    chk(out_first === 1'b0, tag, "out_first in reset", 32'(out_first), 0);
    chk(in_ready === 1'b1, tag, "in_ready in reset", 32'(in_ready), 1);
    rst_n = 1'b1;
    fill = 1'b1; slot = 0; ev = 1'b0; ef = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset("R1");

    // directed: fill in natural order (R2), then reversed order (R3, R4)
    for (int i = 0; i < BLK; i++) send(DW'(8'h40 + i), AW'(i), 1'b0);
    for (int i = 0; i < BLK; i++) send(DW'(8'h80 + i), AW'(BLK - 1 - i), 1'b0);
    // directed: long stall with a word waiting (R5), then idle drain (R6)
    begin
      bit acc;
      step(1'b1, 8'hA5, 4'd3, 1'b1, acc);
      for (int k = 0; k < 4; k++) step(1'b1, 8'h5A, 4'd7, 1'b0, acc);
      step(1'b0, 8'hFF, 4'd7, 1'b1, acc);
      step(1'b0, 8'hEE, 4'd9, 1'b1, acc);
      // finish the block with a fixed permutation
      for (int i = 1; i < BLK; i++) send(DW'(8'hC0 + i), perm_addr(i, 5, 3), 1'b0);
    end

    // random blocks with changing permutations, gaps and back-pressure
    for (int b = 0; b < 40; b++) begin
      int mul = 2 * $urandom_range(0, 7) + 1;
      int off = $urandom_range(0, BLK - 1);
      for (int i = 0; i < BLK; i++) send(DW'($urandom), perm_addr(i, mul, off), 1'b1);
    end

    // reset mid-block restarts the fill phase (R7)
    for (int i = 0; i < 7; i++) send(DW'($urandom), perm_addr(i, 3, 1), 1'b1);
    do_reset("R7");
    for (int i = 0; i < BLK; i++) send(DW'($urandom), AW'(i), 1'b1);
    for (int b = 0; b < 10; b++) begin
      int mul = 2 * $urandom_range(0, 7) + 1;
      int off = $urandom_range(0, BLK - 1);
      for (int i = 0; i < BLK; i++) send(DW'($urandom), perm_addr(i, mul, off), 1'b1);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule